// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Unit

This block is the arithmetic core of a fixed-point signal-processing datapath. It multiplies two 17-bit signed operands in a single clock cycle. The product can replace one of two 40-bit accumulators, be added to it, or be subtracted from it. The same port can also clear an accumulator or shift it arithmetically by a signed amount, which aligns it before storage or further accumulation. The 40-bit accumulators keep eight guard bits above a 32-bit fractional field, so long sums can run past full scale without immediate wrap-around.

Two optional post-processing steps can be applied to every arithmetic result before it is written back. Rounding moves the value to the nearest multiple of 2^16. Saturation clamps a value that has left the signed 32-bit range and raises a sticky overflow flag. Every result also updates two registered side outputs. The first is the upper half of the 32-bit field of the written value. The second is a normalisation exponent that a controller can feed back as a shift count.

A sequencer drives one operation per cycle. Instruction decode and operand fetch are outside this block.

Top module: `dmac_unit`

## Requirements
- R1: Reset is synchronous and active high. While it is applied, both accumulators, hi_o, exp_o and ovf_o become 0 at the next rising clock edge.
- R2: op_i = 2 (load product) writes the sign-extended product opa_i*opb_i into the selected accumulator.
- R3: op_i = 3 (accumulate) writes the selected accumulator plus the product into that accumulator. Without saturation the sum wraps modulo 2^40.
- R4: op_i = 4 (deduct) writes the selected accumulator minus the product into that accumulator.
- R5: When frac_i = 1, the product used by operation codes 2, 3 and 4 is doubled (shifted left one bit) before it is used.
- R6: op_i = 1 sets the selected accumulator to zero. op_i = 0, 6 and 7 change no accumulator and no output.
- R7: When rnd_i = 1, a write by operation codes 2 to 5 first adds 2^15 to the result and then forces result bits 15:0 to zero.
- R8: When sat_i = 1 and bits 39:31 of the (rounded) result are not all equal, the value written is 0x007FFFFFFF for a non-negative bit 39 and 0xFF80000000 otherwise. The same case sets ovf_o, which stays 1 until reset. With sat_i = 0, no clamping happens and ovf_o is not set.
- R9: op_i = 5 shifts the selected accumulator arithmetically by shamt_i, a 6-bit two's-complement count. A positive count shifts left, a negative count shifts right with sign fill, and counts below -16 act as -16.
- R10: After every write by operation codes 1 to 5, hi_o shows bits 31:16 of the value written.
- R11: After every write by operation codes 1 to 5, exp_o (signed) shows the number of bits directly below bit 39 that equal bit 39, minus 8. A zero value gives 31.
- R12: sel_i = 0 targets accumulator A and sel_i = 1 targets accumulator B. The accumulator that is not selected never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation: 0 idle, 1 clear, 2 load product, 3 accumulate, 4 deduct, 5 shift |
| sel_i | input | 1 | Accumulator select (0 = A, 1 = B) |
| frac_i | input | 1 | Fractional mode, doubles the product |
| rnd_i | input | 1 | Round enable |
| sat_i | input | 1 | Saturation enable |
| shamt_i | input | 6 | Signed shift count for operation 5 |
| opa_i | input | 17 | Signed multiplicand |
| opb_i | input | 17 | Signed multiplier |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |
| hi_o | output | 16 | Bits 31:16 of the last value written |
| exp_o | output | 6 | Signed normalisation exponent of the last value written |
| ovf_o | output | 1 | Sticky saturation flag |

## Verification
The bench drives the most negative operand squared, first alone and then accumulated with saturation on. A design that saturates at 40 bits instead of at the 32-bit range, or that clamps toward the wrong rail, produces a visibly wrong accumulator and a wrong ovf_o. The bench rounds a deduction that lands exactly on minus one half. A design that rounds after clearing, or that truncates, leaves 0xFFFFFF8000 or 0xFFFFFF0000 instead of zero. Shifts are driven with positive, negative and below-range counts, so a design that uses a logical right shift or that misses the -16 clamp gives the wrong value. Idle and unused operation codes are checked against both accumulators, along with the leading-bit exponent of zero, positive and negative values.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_CLR  = 3'd1,
    OP_MPY  = 3'd2,
    OP_MAC  = 3'd3,
    OP_MAS  = 3'd4,
    OP_SHF  = 3'd5
  } mac_op_e;

  // operations that produce an arithmetic result
  function automatic logic op_writes(input logic [2:0] code);
    return (code >= 3'd2) && (code <= 3'd5);
  endfunction

endpackage

// File: rtl/dmac_mul.sv
module dmac_mul #(
  parameter int OP_W  = 17,
  parameter int ACC_W = 40
) (
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  input  logic             frac_i,
  output logic [ACC_W-1:0] prod_o
);
  localparam int PW = 2 * OP_W;

  logic signed [PW-1:0]    raw;
  logic signed [ACC_W-1:0] ext;

  assign raw    = $signed(a_i) * $signed(b_i);
  assign ext    = ACC_W'(raw);
  assign prod_o = frac_i ? (ext <<< 1) : ext;
endmodule

// File: rtl/dmac_shift.sv
module dmac_shift #(
  parameter int ACC_W  = 40,
  parameter int SH_W   = 6,
  parameter int SH_MIN = -16
) (
  input  logic [ACC_W-1:0] x_i,
  input  logic [SH_W-1:0]  amt_i,
  output logic [ACC_W-1:0] y_o
);
  int amt;

  always_comb begin
    amt = int'($signed(amt_i));
    if (amt < SH_MIN) amt = SH_MIN;
    if (amt >= 0) y_o = x_i << amt;
    else          y_o = ACC_W'($signed(x_i) >>> (-amt));
  end
endmodule

// File: rtl/dmac_post.sv
module dmac_post #(
  parameter int ACC_W   = 40,
  parameter int FRAC_W  = 32,
  parameter int RND_POS = 16
) (
  input  logic [ACC_W-1:0] val_i,
  input  logic             rnd_i,
  input  logic             sat_i,
  output logic [ACC_W-1:0] res_o,
  output logic             hit_o
);
  localparam int GW = ACC_W - FRAC_W + 1;
  localparam logic [ACC_W-1:0] HALF    = ACC_W'(1) << (RND_POS - 1);
  localparam logic [ACC_W-1:0] POS_MAX = {{GW{1'b0}}, {(FRAC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_MAX = {{GW{1'b1}}, {(FRAC_W-1){1'b0}}};

  logic [ACC_W-1:0] rsum;
  logic [ACC_W-1:0] rv;
  logic [GW-1:0]    guard;
  logic             uniform;

  assign rsum    = val_i + HALF;
  assign rv      = rnd_i ? {rsum[ACC_W-1:RND_POS], {RND_POS{1'b0}}} : val_i;
  assign guard   = rv[ACC_W-1:FRAC_W-1];
  assign uniform = (guard == '0) || (guard == '1);
  assign hit_o   = sat_i && !uniform;
  assign res_o   = hit_o ? (rv[ACC_W-1] ? NEG_MAX : POS_MAX) : rv;
endmodule

// File: rtl/dmac_exp.sv
module dmac_exp #(
  parameter int ACC_W  = 40,
  parameter int FRAC_W = 32,
  parameter int EXP_W  = 6
) (
  input  logic [ACC_W-1:0] x_i,
  output logic [EXP_W-1:0] exp_o
);
  int   cnt;
  logic run;

  always_comb begin
    cnt = 0;
    run = 1'b1;
    for (int i = ACC_W - 2; i >= 0; i--) begin
      if (run && (x_i[i] == x_i[ACC_W-1])) cnt = cnt + 1;
      else run = 1'b0;
    end
    exp_o = EXP_W'(cnt - (ACC_W - FRAC_W));
  end
endmodule

// File: rtl/dmac_unit.sv
module dmac_unit #(
  parameter int OP_W   = 17,
  parameter int ACC_W  = 40,
  parameter int FRAC_W = 32,
  parameter int SH_W   = 6,
  parameter int SH_MIN = -16,
  parameter int EXP_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [2:0]        op_i,
  input  logic              sel_i,
  input  logic              frac_i,
  input  logic              rnd_i,
  input  logic              sat_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic [OP_W-1:0]   opa_i,
  input  logic [OP_W-1:0]   opb_i,
  output logic [ACC_W-1:0]  acc_a_o,
  output logic [ACC_W-1:0]  acc_b_o,
  output logic [FRAC_W/2-1:0] hi_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic              ovf_o
);
  import dmac_pkg::*;

  localparam int N_ACC  = 2;
  localparam int HI_LSB = FRAC_W / 2;

  logic [ACC_W-1:0]  acc_q [N_ACC];
  logic [ACC_W-1:0]  cur;
  logic [ACC_W-1:0]  prod;
  logic [ACC_W-1:0]  shifted;
  logic [ACC_W-1:0]  pre;
  logic [ACC_W-1:0]  post;
  logic [ACC_W-1:0]  nxt;
  logic [EXP_W-1:0]  nxt_exp;
  logic              sat_hit;
  logic              wr;
  logic              clr;
  logic [HI_LSB-1:0] hi_q;
  logic [EXP_W-1:0]  exp_q;
  logic              ovf_q;

  assign cur = acc_q[sel_i];
  assign wr  = op_writes(op_i);
  assign clr = (op_i == OP_CLR);

  dmac_mul #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mul (
    .a_i(opa_i), .b_i(opb_i), .frac_i(frac_i), .prod_o(prod)
  );

  dmac_shift #(.ACC_W(ACC_W), .SH_W(SH_W), .SH_MIN(SH_MIN)) u_shift (
    .x_i(cur), .amt_i(shamt_i), .y_o(shifted)
  );

  always_comb begin
    case (mac_op_e'(op_i))
      OP_MPY:  pre = prod;
      OP_MAC:  pre = cur + prod;
      OP_MAS:  pre = cur - prod;
      OP_SHF:  pre = shifted;
      default: pre = cur;
    endcase
  end

  dmac_post #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .RND_POS(HI_LSB)) u_post (
    .val_i(pre), .rnd_i(rnd_i), .sat_i(sat_i), .res_o(post), .hit_o(sat_hit)
  );

  assign nxt = clr ? '0 : post;

  dmac_exp #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_exp (
    .x_i(nxt), .exp_o(nxt_exp)
  );

  for (genvar gi = 0; gi < N_ACC; gi++) begin : g_acc
    always_ff @(posedge clk_i) begin
      if (rst_i)
        acc_q[gi] <= '0;
      else if ((wr || clr) && (int'(sel_i) == gi))
        acc_q[gi] <= nxt;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hi_q  <= '0;
      exp_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (wr || clr) begin
        hi_q  <= nxt[FRAC_W-1:HI_LSB];
        exp_q <= nxt_exp;
      end
      if (wr && sat_hit) ovf_q <= 1'b1;
    end
  end

  assign acc_a_o = acc_q[0];
  assign acc_b_o = acc_q[1];
  assign hi_o    = hi_q;
  assign exp_o   = exp_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/dmac_unit_chk.sv
module dmac_unit_chk #(
  parameter int ACC_W  = 40,
  parameter int FRAC_W = 32,
  parameter int EXP_W  = 6
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [2:0]        op_i,
  input logic              sel_i,
  input logic              rnd_i,
  input logic              sat_i,
  input logic [ACC_W-1:0]  acc_a_o,
  input logic [ACC_W-1:0]  acc_b_o,
  input logic [FRAC_W/2-1:0] hi_o,
  input logic              ovf_o
);
  localparam int HI_LSB = FRAC_W / 2;
  logic wr;
  assign wr = (op_i >= 3'd2) && (op_i <= 3'd5);

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    rst_i |=> (acc_a_o == '0 && acc_b_o == '0 && hi_o == '0 && !ovf_o)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i == 3'd0) |=> ($stable(acc_a_o) && $stable(acc_b_o))); // R6

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i == 3'd1 && !sel_i) |=> (acc_a_o == '0)); // R6

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    ovf_o |=> ovf_o); // R8

  AST_SAT_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr && sat_i && !sel_i) |=>
      (acc_a_o[ACC_W-1:FRAC_W-1] == '0 || acc_a_o[ACC_W-1:FRAC_W-1] == '1)); // R8

  AST_ROUND_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr && rnd_i && !sat_i && sel_i) |=> (acc_b_o[HI_LSB-1:0] == '0)); // R7

  AST_B_UNTOUCHED: assert property (@(posedge clk_i) disable iff (rst_i)
    !sel_i |=> $stable(acc_b_o)); // R12

  AST_A_UNTOUCHED: assert property (@(posedge clk_i) disable iff (rst_i)
    sel_i |=> $stable(acc_a_o)); // R12
endmodule

bind dmac_unit dmac_unit_chk #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .op_i(op_i), .sel_i(sel_i), .rnd_i(rnd_i),
  .sat_i(sat_i), .acc_a_o(acc_a_o), .acc_b_o(acc_b_o), .hi_o(hi_o), .ovf_o(ovf_o)
);

// File: tb/tb_dmac_unit.sv
`timescale 1ns/1ps
module tb_dmac_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  op;
  logic        sel, frac, rnd, sat;
  logic [5:0]  shamt;
  logic [16:0] opa, opb;
  logic [39:0] acc_a, acc_b;
  logic [15:0] hi;
  logic [5:0]  ex;
  logic        ovf;

  int total = 0;
  int fails = 0;
  logic done = 1'b0;
  logic [39:0] mod_a, mod_b;

  always #2.5 clk = ~clk;

  dmac_unit dut (
    .clk_i(clk), .rst_i(rst), .op_i(op), .sel_i(sel), .frac_i(frac),
    .rnd_i(rnd), .sat_i(sat), .shamt_i(shamt), .opa_i(opa), .opb_i(opb),
    .acc_a_o(acc_a), .acc_b_o(acc_b), .hi_o(hi), .exp_o(ex), .ovf_o(ovf)
  );

  // fields: op, sel, frac, rnd, sat, shamt, opa, opb | acc, hi, exp, ovf
  localparam int VW = 110;
  localparam logic [VW-1:0] VEC [0:12] = '{
    {3'd2,1'b0,1'b0,1'b0,1'b0,6'd0, 17'd3,     17'd5,     40'h000000000F,16'h0000,6'd27,1'b0},
    {3'd3,1'b0,1'b0,1'b0,1'b0,6'd0, 17'h1FFF9, 17'd4,     40'hFFFFFFFFF3,16'hFFFF,6'd27,1'b0},
    {3'd2,1'b1,1'b1,1'b0,1'b0,6'd0, 17'd100,   17'd200,   40'h0000009C40,16'h0000,6'd15,1'b0},
    {3'd4,1'b1,1'b0,1'b0,1'b0,6'd0, 17'd1000,  17'd10,    40'h0000007530,16'h0000,6'd16,1'b0},
    {3'd2,1'b0,1'b0,1'b1,1'b0,6'd0, 17'h01234, 17'd16,    40'h0000010000,16'h0001,6'd14,1'b0},
    {3'd4,1'b0,1'b0,1'b1,1'b0,6'd0, 17'd3,     17'h08000, 40'h0000000000,16'h0000,6'd31,1'b0},
    {3'd5,1'b1,1'b0,1'b0,1'b0,6'd8, 17'd0,     17'd0,     40'h0000753000,16'h0075,6'd8, 1'b0},
    {3'd5,1'b1,1'b0,1'b0,1'b0,6'h3C,17'd0,     17'd0,     40'h0000075300,16'h0007,6'd12,1'b0},
    {3'd5,1'b1,1'b0,1'b0,1'b0,6'h2C,17'd0,     17'd0,     40'h0000000007,16'h0000,6'd28,1'b0},
    {3'd2,1'b0,1'b0,1'b0,1'b0,6'd0, 17'h10000, 17'h10000, 40'h0100000000,16'h0000,6'h3E,1'b0},
    {3'd3,1'b0,1'b0,1'b0,1'b1,6'd0, 17'h10000, 17'h10000, 40'h007FFFFFFF,16'h7FFF,6'd0, 1'b1},
    {3'd2,1'b1,1'b0,1'b0,1'b1,6'd0, 17'h10000, 17'h0FFFF, 40'hFF80000000,16'h8000,6'd0, 1'b1},
    {3'd1,1'b0,1'b0,1'b0,1'b0,6'd0, 17'd0,     17'd0,     40'h0000000000,16'h0000,6'd31,1'b1}
  };

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp_v);
    total++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  function automatic string op_req(input logic [2:0] code, input logic fr,
                                   input logic rd, input logic st);
    if (st) return "R8";
    if (rd) return "R7";
    if (fr) return "R5";
    case (code)
      3'd1: return "R6";
      3'd2: return "R2";
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R9";
      default: return "R6";
    endcase
  endfunction

  task automatic drive(input logic [2:0] o, input logic s, input logic [16:0] a,
                       input logic [16:0] b);
    @(negedge clk);
    op = o; sel = s; opa = a; opb = b; frac = 1'b0; rnd = 1'b0; sat = 1'b0; shamt = '0;
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst = 1'b1; op = '0; sel = 1'b0; frac = 1'b0; rnd = 1'b0; sat = 1'b0;
    shamt = '0; opa = '0; opb = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 acc A", acc_a, 40'h0);
    chk("R1 acc B", acc_b, 40'h0);
    chk("R1 hi", {24'h0, hi}, 40'h0);
    chk("R1 exp", {34'h0, ex}, 40'h0);
    chk("R1 ovf", {39'h0, ovf}, 40'h0);
    @(negedge clk);
    rst = 1'b0;
    mod_a = '0; mod_b = '0;

    for (int i = 0; i < 13; i++) begin
      logic [VW-1:0] v;
      string rq;
      v = VEC[i];
      @(negedge clk);
      op = v[109:107]; sel = v[106]; frac = v[105]; rnd = v[104]; sat = v[103];
      shamt = v[102:97]; opa = v[96:80]; opb = v[79:63];
      @(posedge clk);
      #1;
      rq = op_req(v[109:107], v[105], v[104], v[103]);
      if (v[106]) mod_b = v[62:23]; else mod_a = v[62:23];
      chk(v[106] ? "R12 acc A" : rq, acc_a, mod_a);
      chk(v[106] ? rq : "R12 acc B", acc_b, mod_b);
      chk("R10 hi", {24'h0, hi}, {24'h0, v[22:7]});
      chk("R11 exp", {34'h0, ex}, {34'h0, v[6:1]});
      chk("R8 ovf", {39'h0, ovf}, {39'h0, v[0]});
    end

    // R6: idle and unused codes leave everything as it was
    drive(3'd0, 1'b1, 17'd9, 17'd9);
    chk("R6 idle A", acc_a, mod_a);
    chk("R6 idle B", acc_b, mod_b);
    chk("R6 idle hi", {24'h0, hi}, 40'h0);
    drive(3'd6, 1'b1, 17'd9, 17'd9);
    chk("R6 code6 B", acc_b, mod_b);
    drive(3'd7, 1'b0, 17'd9, 17'd9);
    chk("R6 code7 A", acc_a, mod_a);
    chk("R6 code7 exp", {34'h0, ex}, 40'd31);

    // R3: accumulate into B without saturation keeps going past 32 bits
    drive(3'd3, 1'b1, 17'h10000, 17'h10000);
    mod_b = 40'hFF80000000 + 40'h0100000000;
    chk("R3 no-sat B", acc_b, mod_b);
    chk("R8 ovf still set", {39'h0, ovf}, 40'h1);

    // R1: reset mid-run clears sticky flag and accumulators
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 re-reset B", acc_b, 40'h0);
    chk("R1 re-reset ovf", {39'h0, ovf}, 40'h0);
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule